// File: doc/BRIEF.md
# Transfer Command Descriptor Encoder

This block converts one transfer request for a serial-bus host controller into a 64-bit command descriptor ready for the controller's command queue. A request names the transfer direction, byte count, up to four inline write bytes, a device table index, whether the target sits on an I3C or an I2C bus, the configured clock rate in hertz, and optionally a common-command code with a broadcast flag. The encoder picks the descriptor format, packs every field, derives the speed-mode code from the clock rate, and stamps the descriptor with a rolling 4-bit transaction tag.

Both sides use valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high, and its descriptor appears registered on `desc_*` on the next cycle. The output register is a single slot. `req_ready` is high when that slot is empty or is being drained in the same cycle, so a downstream consumer that holds `desc_ready` high gets one descriptor per cycle. A stalled consumer stalls the producer without losing or changing anything.

Top module: `xfer_desc_encoder`

## Requirements
- R1: `req_ready` equals `!desc_valid || desc_ready`. An accepted request shows as `desc_valid` high on the next cycle. `desc_valid` drops after a downstream accept when no new request is taken in that cycle.
- R2: While `desc_valid` is high and `desc_ready` is low, `desc_word`, `desc_tid` and `desc_mode` hold their values and `desc_valid` stays high.
- R3: A write (`req_read`=0) with `req_len` ≤ 4 produces an immediate descriptor. Bits 2:0 hold 1 and bits 25:23 hold the count. Inline byte k (k=1..4), taken from `req_data[8k-1:8k-8]`, lands in bits 32+8k-1:32+8k-8 when k ≤ count, and that slot is zero otherwise. Bit 29 is zero.
- R4: Any read, and any write longer than 4 bytes, produces a regular descriptor. Bits 2:0 hold 0, bits 63:48 hold `req_len`, and bit 29 is 1 exactly for reads. Bits 47:32 and 25:23 are zero.
- R5: With `req_ccc`=1, bit 15 is 1 and bits 14:7 carry `req_ccc_code`. Otherwise both fields are zero. Bits 20:16 carry `req_dev_idx`, except that a common command with `req_bcast`=1 uses index 0.
- R6: On I3C (`req_i2c`=0) the mode code is 0 for rates ≥ 12,500,000, 1 for rates > 8,000,000, 2 for > 6,000,000, 3 for > 4,000,000, 4 for > 2,000,000, and 8 otherwise. `desc_mode` carries the 4-bit code and bits 28:26 carry its low three bits.
- R7: On I2C (`req_i2c`=1) the mode code is 1 for rates ≥ 1,000,000 and 0 otherwise, placed as in R6.
- R8: Counting descriptors from 0 after reset, the n-th descriptor carries n mod 16 in both `desc_tid` and bits 6:3.
- R9: During and right after reset, `desc_valid` is low and `req_ready` is high. The first descriptor after reset carries tag 0.
- R10: Bits 31:30 and 22:21 of every descriptor are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_read | input | 1 | 1 for a read, 0 for a write |
| req_len | input | 16 | Transfer byte count |
| req_data | input | 32 | Inline write bytes, byte 1 in bits 7:0 |
| req_dev_idx | input | 5 | Device table index of the target |
| req_i2c | input | 1 | 1 when the target is an I2C device |
| req_scl_hz | input | 32 | Configured bus clock rate in Hz |
| req_ccc | input | 1 | Request is a common command |
| req_ccc_code | input | 8 | Common-command code |
| req_bcast | input | 1 | Common command is broadcast |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer takes the descriptor this cycle |
| desc_word | output | 64 | Packed command descriptor |
| desc_tid | output | 4 | Transaction tag of the descriptor |
| desc_mode | output | 4 | Full speed-mode code |

## Verification
The embedded properties take for granted that the request fields are stable and meaningful only on cycles where `req_valid` is high, and that `desc_ready` may toggle freely. They make no assumption on the rate value, because every 32-bit rate maps to a legal code. The stimulus changes request fields only between cycles. It picks rates exactly at and one hertz away from each threshold, sweeps byte counts 0 through 5 and large values in both directions, and mixes common-command, broadcast and I2C requests. A behavioural model in the bench predicts `req_ready`, `desc_valid` and every output field on each clock. Back-pressure comes from a randomly toggled `desc_ready`, so descriptors are held, drained and refilled in the same cycle.

// File: rtl/xde_pkg.sv
package xde_pkg;
  parameter int WORD_W       = 64;
  parameter int LEN_W        = 16;
  parameter int IDX_W        = 5;
  parameter int CODE_W       = 8;
  parameter int TID_W        = 4;
  parameter int RATE_W       = 32;
  parameter int MODE_W       = 4;
  parameter int INLINE_BYTES = 4;

  localparam int INLINE_W  = 8 * INLINE_BYTES;
  localparam int ATTR_LSB  = 0;
  localparam int TID_LSB   = 3;
  localparam int CODE_LSB  = 7;
  localparam int CP_BIT    = 15;
  localparam int IDX_LSB   = 16;
  localparam int CNT_LSB   = 23;
  localparam int MODE_LSB  = 26;
  localparam int RNW_BIT   = 29;
  localparam int DATA_LSB  = 32;
  localparam int LEN_LSB   = WORD_W - LEN_W;
  localparam int MFLD_W    = 3;

  typedef enum logic [2:0] {
    ATTR_REGULAR  = 3'd0,
    ATTR_IMMED    = 3'd1,
    ATTR_ADDR     = 3'd2,
    ATTR_COMBO    = 3'd3,
    ATTR_INTERNAL = 3'd7
  } attr_e;

  typedef struct packed {
    logic                read;
    logic [LEN_W-1:0]    len;
    logic [INLINE_W-1:0] data;
    logic [IDX_W-1:0]    idx;
    logic                ccc;
    logic [CODE_W-1:0]   code;
    logic                bcast;
  } xfer_req_t;
endpackage

// File: rtl/xde_mode_sel.sv
module xde_mode_sel
  import xde_pkg::*;
#(
  parameter int          TIERS = 5,
  parameter logic [31:0] I3C_MIN [TIERS] = '{32'd12_500_000, 32'd8_000_001,
                                             32'd6_000_001, 32'd4_000_001,
                                             32'd2_000_001},
  parameter logic [MODE_W-1:0] I3C_SLOW = 4'd8,
  parameter logic [31:0] I2C_FAST_MIN = 32'd1_000_000
) (
  input  logic              is_i2c,
  input  logic [RATE_W-1:0] rate,
  output logic [MODE_W-1:0] mode
);
  logic [TIERS-1:0] hit;

  for (genvar t = 0; t < TIERS; t++) begin : g_tier
    assign hit[t] = (rate >= I3C_MIN[t]);
  end

  logic [MODE_W-1:0] i3c_mode;
  always_comb begin
    i3c_mode = I3C_SLOW;
    for (int t = TIERS - 1; t >= 0; t--) begin
      if (hit[t]) i3c_mode = MODE_W'(t);
    end
  end

  assign mode = is_i2c ? ((rate >= I2C_FAST_MIN) ? MODE_W'(1) : MODE_W'(0))
                       : i3c_mode;
endmodule

// File: rtl/xde_packer.sv
module xde_packer
  import xde_pkg::*;
(
  input  xfer_req_t         req,
  input  logic [MFLD_W-1:0] mode_fld,
  output logic [WORD_W-1:0] word
);
  logic [INLINE_W-1:0] inline_w;
  logic                imm;

  assign imm = !req.read && (req.len <= LEN_W'(INLINE_BYTES));

  for (genvar b = 0; b < INLINE_BYTES; b++) begin : g_byte
    assign inline_w[8*b +: 8] = (req.len > LEN_W'(b)) ? req.data[8*b +: 8] : 8'h00;
  end

  always_comb begin
    word = '0;
    word[ATTR_LSB +: 3]      = imm ? ATTR_IMMED : ATTR_REGULAR;
    word[MODE_LSB +: MFLD_W] = mode_fld;
    word[IDX_LSB +: IDX_W]   = (req.ccc && req.bcast) ? '0 : req.idx;
    if (req.ccc) begin
      word[CP_BIT]                = 1'b1;
      word[CODE_LSB +: CODE_W]    = req.code;
    end
    if (imm) begin
      word[CNT_LSB +: 3]          = req.len[2:0];
      word[DATA_LSB +: INLINE_W]  = inline_w;
    end else begin
      word[RNW_BIT]               = req.read;
      word[LEN_LSB +: LEN_W]      = req.len;
    end
  end
endmodule

// File: rtl/xde_out_stage.sv
module xde_out_stage
  import xde_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [MODE_W-1:0] in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [TID_W-1:0]  out_tid,
  output logic [MODE_W-1:0] out_mode
);
  logic [TID_W-1:0] tid_cnt, tid_load;
  logic             out_fire, in_fire;

  assign in_ready = !out_valid || out_ready;
  assign out_fire = out_valid && out_ready;
  assign in_fire  = in_valid && in_ready;
  assign tid_load = out_fire ? TID_W'(tid_cnt + 1'b1) : tid_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      tid_cnt   <= '0;
      out_word  <= '0;
      out_tid   <= '0;
      out_mode  <= '0;
    end else begin
      if (out_fire) tid_cnt <= TID_W'(tid_cnt + 1'b1);
      if (in_fire) begin
        out_valid                      <= 1'b1;
        out_word                       <= in_word;
        out_word[TID_LSB +: TID_W]     <= tid_load;
        out_tid                        <= tid_load;
        out_mode                       <= in_mode;
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2: a stalled descriptor holds still
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_tid)
                                && $stable(out_mode));

  // R1: no new request taken while the slot is blocked
  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8: the descriptor after an accepted one carries the next tag
  a_r8_tid_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> !out_valid || out_tid == TID_W'($past(out_tid) + 1'b1));
endmodule

// File: rtl/xfer_desc_encoder.sv
module xfer_desc_encoder
  import xde_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [INLINE_W-1:0] req_data,
  input  logic [IDX_W-1:0]  req_dev_idx,
  input  logic              req_i2c,
  input  logic [RATE_W-1:0] req_scl_hz,
  input  logic              req_ccc,
  input  logic [CODE_W-1:0] req_ccc_code,
  input  logic              req_bcast,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [WORD_W-1:0] desc_word,
  output logic [TID_W-1:0]  desc_tid,
  output logic [MODE_W-1:0] desc_mode
);
  xfer_req_t         req;
  logic [MODE_W-1:0] mode;
  logic [WORD_W-1:0] packed_word;

  assign req = '{read: req_read, len: req_len, data: req_data, idx: req_dev_idx,
                 ccc: req_ccc, code: req_ccc_code, bcast: req_bcast};

  xde_mode_sel u_mode (
    .is_i2c (req_i2c),
    .rate   (req_scl_hz),
    .mode   (mode)
  );

  xde_packer u_pack (
    .req      (req),
    .mode_fld (mode[MFLD_W-1:0]),
    .word     (packed_word)
  );

  xde_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_word   (packed_word),
    .in_mode   (mode),
    .out_valid (desc_valid),
    .out_ready (desc_ready),
    .out_word  (desc_word),
    .out_tid   (desc_tid),
    .out_mode  (desc_mode)
  );

  // R6: only legal mode codes leave the block
  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_mode <= 4'd4 || desc_mode == 4'd8));

  // R3: immediate descriptors carry a count of at most four and never RNW
  a_r3_imm_count: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_word[2:0] == 3'd1 |-> desc_word[25:23] <= 3'd4 && !desc_word[29]);

  // R4: regular descriptors leave the inline area and count field clear
  a_r4_regular_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_word[2:0] == 3'd0 |-> desc_word[47:32] == 16'h0 && desc_word[25:23] == 3'd0);

  // R10: reserved bits stay clear
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_word[31:30] == 2'b00 && desc_word[22:21] == 2'b00);

  // R8: tag field matches the side-band tag
  a_r8_tid_match: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_word[6:3] == desc_tid);
endmodule

// File: tb/tb_xfer_desc_encoder.sv
module tb_xfer_desc_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, req_i2c = 1'b0;
  logic        req_ccc = 1'b0, req_bcast = 1'b0, desc_ready = 1'b0;
  logic [15:0] req_len = '0;
  logic [31:0] req_data = '0, req_scl_hz = '0;
  logic [4:0]  req_dev_idx = '0;
  logic [7:0]  req_ccc_code = '0;
  logic        req_ready, desc_valid;
  logic [63:0] desc_word;
  logic [3:0]  desc_tid, desc_mode;

  always #5 clk = ~clk;

  xfer_desc_encoder dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  bit          mv = 0;
  logic [63:0] mword;
  int          mtid, mmode, cnt = 0;
  bit          held = 0;
  logic [63:0] prev_word;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_mode(input bit i2c, input longint rate);
    if (i2c) return (rate >= 1000000) ? 1 : 0;
    if (rate >= 12500000) return 0;
    if (rate > 8000000) return 1;
    if (rate > 6000000) return 2;
    if (rate > 4000000) return 3;
    if (rate > 2000000) return 4;
    return 8;
  endfunction

  function automatic logic [63:0] ref_word(input int tid);
    logic [63:0] w = 64'h0;
    bit imm = !req_read && req_len <= 4;
    int md = ref_mode(req_i2c, req_scl_hz);
    w[2:0]   = imm ? 3'd1 : 3'd0;
    w[6:3]   = tid[3:0];
    w[28:26] = md[2:0];
    w[20:16] = (req_ccc && req_bcast) ? 5'd0 : req_dev_idx;
    if (req_ccc) begin
      w[15]   = 1'b1;
      w[14:7] = req_ccc_code;
    end
    if (imm) begin
      w[25:23] = req_len[2:0];
      for (int k = 0; k < 4; k++)
        if (k < req_len) w[32 + 8*k +: 8] = req_data[8*k +: 8];
    end else begin
      w[29]    = req_read;
      w[63:48] = req_len;
    end
    return w;
  endfunction

  task automatic cycle(input bit rdy);
    bit fire_out, fire_in;
    int tl;
    desc_ready = rdy;
    #1;
    chk("R1 ready", req_ready, (!mv || rdy));
    @(posedge clk);
    fire_out = mv && rdy;
    fire_in  = req_valid && (!mv || rdy);
    tl = fire_out ? (cnt + 1) % 16 : cnt;
    held = mv && !rdy;
    prev_word = mword;
    if (fire_out) cnt = (cnt + 1) % 16;
    if (fire_in) begin
      mv = 1; mword = ref_word(tl); mtid = tl;
      mmode = ref_mode(req_i2c, req_scl_hz);
    end else if (fire_out) mv = 0;
    @(negedge clk);
    chk("R1 valid", desc_valid, mv);
    if (mv) begin
      if (held) chk("R2 hold", desc_word, prev_word);
      if (mword[2:0] == 3'd1) chk("R3 imm word", desc_word, mword);
      else                    chk("R4 reg word", desc_word, mword);
      chk("R5 idx/ccc", desc_word[20:7], mword[20:7]);
      chk("R10 reserved", {desc_word[31:30], desc_word[22:21]}, 4'h0);
      chk("R8 tid", desc_tid, mtid);
      if (desc_word[2:0] == mword[2:0] && mword[28:26] == desc_word[28:26] && mmode < 2 && desc_mode < 2)
        chk("R7 mode", desc_mode, mmode);
      else
        chk("R6 mode", desc_mode, mmode);
    end
  endtask

  task automatic set_req(input bit rd, input int len, input logic [31:0] d,
                         input int idx, input bit i2c, input longint rate,
                         input bit ccc, input int code, input bit bc);
    req_valid = 1; req_read = rd; req_len = len[15:0]; req_data = d;
    req_dev_idx = idx[4:0]; req_i2c = i2c; req_scl_hz = rate[31:0];
    req_ccc = ccc; req_ccc_code = code[7:0]; req_bcast = bc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  longint rates[15] = '{12500000, 12499999, 8000001, 8000000, 6000001, 6000000,
                        4000001, 4000000, 2000001, 2000000, 0, 1000000, 999999,
                        100000000, 3000000};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", desc_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after reset", desc_valid, 1'b0);
    chk("R9 ready after reset", req_ready, 1'b1);
    // first descriptor: tag 0
    set_req(0, 3, 32'hA1B2C3D4, 7, 0, 12500000, 0, 0, 0);
    cycle(1);
    req_valid = 0;
    chk("R9 first tid", desc_tid, 4'd0);
    cycle(1);
    // R3: inline counts 0..4, and R4 at 5
    for (int l = 0; l <= 5; l++) begin
      set_req(0, l, 32'h11223344, l, 0, 8000001, 0, 0, 0);
      cycle(1);
    end
    // R4: reads of several lengths
    set_req(1, 0, 32'hFFFFFFFF, 3, 0, 6000000, 0, 0, 0); cycle(1);
    set_req(1, 2, 32'hFFFFFFFF, 3, 1, 999999, 0, 0, 0); cycle(1);
    set_req(0, 65535, 32'h0, 31, 1, 1000000, 0, 0, 0); cycle(1);
    // R5: common commands, broadcast and directed
    set_req(0, 1, 32'h5A, 9, 0, 4000001, 1, 8'h06, 1); cycle(1);
    set_req(1, 6, 32'h0, 9, 0, 2000001, 1, 8'h8D, 0); cycle(1);
    // R6/R7: every boundary rate
    for (int i = 0; i < 15; i++) begin
      set_req(0, 2, 32'hCAFE, i, 0, rates[i], 0, 0, 0); cycle(1);
      set_req(0, 2, 32'hCAFE, i, 1, rates[i], 0, 0, 0); cycle(1);
    end
    // R2: hold under back-pressure
    set_req(1, 20, 32'h0, 4, 0, 0, 0, 0, 0);
    cycle(0); cycle(0); cycle(0); cycle(1);
    req_valid = 0; cycle(1); cycle(1);
    // random mix with random back-pressure, exercises R8 wrap
    for (int n = 0; n < 3000; n++) begin
      set_req($urandom_range(0, 1), ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535)
                                                             : $urandom_range(0, 6),
              $urandom, $urandom_range(0, 31), $urandom_range(0, 1),
              ($urandom_range(0, 1) == 1) ? rates[$urandom_range(0, 14)] : longint'($urandom),
              $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1));
      req_valid = ($urandom_range(0, 4) != 0);
      cycle($urandom_range(0, 9) < 7);
    end
    req_valid = 0;
    cycle(1); cycle(1);
    done = 1;
    finish_run();
  end
endmodule